// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This unit executes the register-to-register arithmetic and logical instructions of a 32-bit load/store processor. Each issued operation arrives with a 5-bit operation code, a first operand read from the base register, a second operand already produced by the barrel shifter, and that shifter's carry-out. The unit returns the value to be written back, a write-enable for the destination register, and the four condition flags: negative, zero, carry and overflow.

Bits [4:1] of the operation code hold the 4-bit opcode and bit 0 holds the set-flags bit. Logical operations take their carry from the shifter and keep the overflow flag. Arithmetic operations compute their own carry and overflow. Two test-only operations update the flags without writing a register. A flag-setting operation whose destination is the program counter does not update the flags. Instead it raises a request to the surrounding core to restore the saved status word.

Results are registered one cycle after an issue strobe. The flags live in this unit as persistent state.

Top module: `dp_alu_unit`

## Requirements
- R1: The operation code is {opcode[3:0], set_flags}; a code with bit 0 clear never changes the flags.
- R2: Logical codes write these results: AND 0/1 = rn & sh, EOR 2/3 = rn ^ sh, ORR 24/25 = rn | sh, MOV 26/27 = sh, BIC 28/29 = rn & ~sh, MVN 30/31 = ~sh, with rd_we set.
- R3: Arithmetic codes write modulo 2^32: SUB 4/5 = rn - sh, RSB 6/7 = sh - rn, ADD 8/9 = rn + sh, with rd_we set.
- R4: A flag-setting operation that updates the flags sets N to result bit 31 and sets Z when all 32 result bits are zero.
- R5: ADD (9) and CMN (23) set C to the carry out of bit 31 and set V when both operands have equal sign bits and the sum's sign differs from them.
- R6: SUB (5), RSB (7) and CMP (21) set C when minuend >= subtrahend as unsigned values, and set V to bit 31 of ((minuend ^ subtrahend) & (result ^ minuend)).
- R7: Flag-setting logical codes copy sh_carry into C and leave V unchanged.
- R8: CMP (21) and CMN (23) update all four flags, present rn - sh or rn + sh on result, never set rd_we, and never raise restore_req, whatever rd_idx holds.
- R9: A flag-setting writing code with rd_idx == 15 raises restore_req with rd_we set and leaves all flags unchanged.
- R10: Codes 10 to 20 and 22 set neither rd_we nor restore_req and leave the flags unchanged.
- R11: An operation issued with in_valid at a clock edge presents out_valid, result, rd_we, restore_req and the new flags after that edge. In a cycle after an edge without in_valid, out_valid, rd_we and restore_req are 0 and the flags hold.
- R12: A synchronous active-high reset clears the flags, out_valid, rd_we, restore_req and result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe for one operation |
| op_code | input | 5 | {opcode, set_flags} |
| rn_val | input | DATA_W | First operand (base register) |
| sh_val | input | DATA_W | Second operand from the shifter |
| sh_carry | input | 1 | Shifter carry-out |
| rd_idx | input | REG_IDX_W | Destination register number |
| out_valid | output | 1 | Result presented this cycle |
| result | output | DATA_W | Computed value |
| rd_we | output | 1 | Destination write-enable |
| restore_req | output | 1 | Request to restore the saved status |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The flags are the only state that outlives an operation. A wrong flag value therefore stays hidden until the flags are read, and an unwanted update shows only on the flag outputs one cycle after the issue that caused it. The bench compares the flags after every issue and after every idle cycle, so a stray update or a lost hold is caught within one cycle. A wrong decode of a code shows in the same cycle as a wrong rd_we or restore_req. The sweep covers every code with operands at the sign and carry boundaries, with both values of the shifter carry and with both an ordinary destination and the program counter.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;

  localparam logic [3:0] OPC_AND = 4'd0;
  localparam logic [3:0] OPC_EOR = 4'd1;
  localparam logic [3:0] OPC_SUB = 4'd2;
  localparam logic [3:0] OPC_RSB = 4'd3;
  localparam logic [3:0] OPC_ADD = 4'd4;
  localparam logic [3:0] OPC_CMP = 4'd10;
  localparam logic [3:0] OPC_CMN = 4'd11;
  localparam logic [3:0] OPC_ORR = 4'd12;
  localparam logic [3:0] OPC_MOV = 4'd13;
  localparam logic [3:0] OPC_BIC = 4'd14;
  localparam logic [3:0] OPC_MVN = 4'd15;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  typedef struct packed {
    logic       writes_rd;
    logic       test_only;
    logic       is_logic;
    logic       arith_sub;
    logic       arith_swap;
    logic       set_flags;
    logic [3:0] opc;
  } op_dec_t;

endpackage

// File: rtl/dpalu_decode.sv
module dpalu_decode
  import dpalu_pkg::*;
(
  input  logic [4:0] op_code,
  output op_dec_t    dec
);

  always_comb begin
    dec = '0;
    dec.opc = op_code[4:1];
    case (op_code[4:1])
      OPC_AND, OPC_EOR, OPC_ORR, OPC_MOV, OPC_BIC, OPC_MVN: begin
        dec.writes_rd = 1'b1;
        dec.is_logic  = 1'b1;
      end
      OPC_SUB: begin
        dec.writes_rd = 1'b1;
        dec.arith_sub = 1'b1;
      end
      OPC_RSB: begin
        dec.writes_rd  = 1'b1;
        dec.arith_sub  = 1'b1;
        dec.arith_swap = 1'b1;
      end
      OPC_ADD: begin
        dec.writes_rd = 1'b1;
      end
      OPC_CMP: begin
        dec.test_only = op_code[0];
        dec.arith_sub = 1'b1;
      end
      OPC_CMN: begin
        dec.test_only = op_code[0];
      end
      default: ;
    endcase
    dec.set_flags = op_code[0] & (dec.writes_rd | dec.test_only);
  end

endmodule

// File: rtl/dpalu_logic.sv
module dpalu_logic
  import dpalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        opc,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    case (opc)
      OPC_AND: y = a & b;
      OPC_EOR: y = a ^ b;
      OPC_ORR: y = a | b;
      OPC_MOV: y = b;
      OPC_BIC: y = a & ~b;
      OPC_MVN: y = ~b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/dpalu_arith.sv
module dpalu_arith #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              swap,
  output logic [DATA_W-1:0] sum,
  output logic              carry,
  output logic              ovf
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] op1, op2, op2_eff;
  logic [DATA_W:0]   wide;

  always_comb begin
    op1     = swap ? b : a;
    op2     = swap ? a : b;
    op2_eff = sub ? ~op2 : op2;
    // subtraction as op1 + ~op2 + 1: carry-out high means no borrow
    wide    = {1'b0, op1} + {1'b0, op2_eff} + {{DATA_W{1'b0}}, sub};
    sum     = wide[MSB:0];
    carry   = wide[DATA_W];
    if (sub) ovf = ((op1 ^ op2) & (sum ^ op1)) >> MSB != '0;
    else     ovf = (~(op1 ^ op2) & (sum ^ op1)) >> MSB != '0;
  end

endmodule

// File: rtl/dpalu_flag_next.sv
module dpalu_flag_next
  import dpalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              is_logic,
  input  logic [DATA_W-1:0] res,
  input  logic              arith_c,
  input  logic              arith_v,
  input  logic              sh_carry,
  input  nzcv_t             cur,
  output nzcv_t             nxt
);

  always_comb begin
    nxt.n = res[DATA_W-1];
    nxt.z = (res == '0);
    nxt.c = is_logic ? sh_carry : arith_c;
    nxt.v = is_logic ? cur.v : arith_v;
  end

endmodule

// File: rtl/dp_alu_unit.sv
module dp_alu_unit
  import dpalu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_IDX_W = 4,
  parameter int PC_REG    = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [4:0]           op_code,
  input  logic [DATA_W-1:0]    rn_val,
  input  logic [DATA_W-1:0]    sh_val,
  input  logic                 sh_carry,
  input  logic [REG_IDX_W-1:0] rd_idx,
  output logic                 out_valid,
  output logic [DATA_W-1:0]    result,
  output logic                 rd_we,
  output logic                 restore_req,
  output logic                 flag_n,
  output logic                 flag_z,
  output logic                 flag_c,
  output logic                 flag_v
);

  localparam logic [REG_IDX_W-1:0] PC_IDX = REG_IDX_W'(PC_REG);

  op_dec_t           dec;
  logic [DATA_W-1:0] logic_y, arith_y, res_mux;
  logic              arith_c, arith_v;
  nzcv_t             flags_q, flags_nxt;
  logic              want_restore, flag_upd;

  dpalu_decode u_dec (
    .op_code (op_code),
    .dec     (dec)
  );

  dpalu_logic #(.DATA_W(DATA_W)) u_logic (
    .opc (dec.opc),
    .a   (rn_val),
    .b   (sh_val),
    .y   (logic_y)
  );

  dpalu_arith #(.DATA_W(DATA_W)) u_arith (
    .a     (rn_val),
    .b     (sh_val),
    .sub   (dec.arith_sub),
    .swap  (dec.arith_swap),
    .sum   (arith_y),
    .carry (arith_c),
    .ovf   (arith_v)
  );

  assign res_mux = dec.is_logic ? logic_y : arith_y;

  dpalu_flag_next #(.DATA_W(DATA_W)) u_fnext (
    .is_logic (dec.is_logic),
    .res      (res_mux),
    .arith_c  (arith_c),
    .arith_v  (arith_v),
    .sh_carry (sh_carry),
    .cur      (flags_q),
    .nxt      (flags_nxt)
  );

  // a flag-setting write to the program counter hands status back to the core
  assign want_restore = dec.set_flags & dec.writes_rd & (rd_idx == PC_IDX);
  assign flag_upd     = dec.set_flags & ~want_restore;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      rd_we       <= 1'b0;
      restore_req <= 1'b0;
      result      <= '0;
      flags_q     <= '0;
    end else begin
      out_valid   <= in_valid;
      rd_we       <= in_valid & dec.writes_rd;
      restore_req <= in_valid & want_restore;
      if (in_valid) result <= res_mux;
      if (in_valid && flag_upd) flags_q <= flags_nxt;
    end
  end

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;

endmodule

// File: rtl/dpalu_checker.sv
module dpalu_checker #(
  parameter int DATA_W    = 32,
  parameter int REG_IDX_W = 4,
  parameter int PC_REG    = 15
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [4:0]           op_code,
  input logic [DATA_W-1:0]    rn_val,
  input logic [DATA_W-1:0]    sh_val,
  input logic                 sh_carry,
  input logic [REG_IDX_W-1:0] rd_idx,
  input logic                 out_valid,
  input logic [DATA_W-1:0]    result,
  input logic                 rd_we,
  input logic                 restore_req,
  input logic                 flag_n,
  input logic                 flag_z,
  input logic                 flag_c,
  input logic                 flag_v
);

  logic [3:0] fl;
  logic       wr_code, cmp_code, logic_s, to_pc;

  assign fl       = {flag_n, flag_z, flag_c, flag_v};
  assign wr_code  = (op_code <= 5'd9) || (op_code >= 5'd24);
  assign cmp_code = (op_code == 5'd21) || (op_code == 5'd23);
  assign logic_s  = op_code[0] && (op_code <= 5'd3 || op_code >= 5'd24);
  assign to_pc    = (rd_idx == REG_IDX_W'(PC_REG));

  assert_even_keeps_flags_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid && !op_code[0] |=> $stable(fl));

  assert_nz_track_result_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid && wr_code && op_code[0] && !to_pc |=>
      flag_n == result[DATA_W-1] && flag_z == (result == '0));

  assert_add_carry_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_code == 5'd9 && !to_pc |=> flag_c == ($past(rn_val) > ~$past(sh_val)));

  assert_sub_no_borrow_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_code == 5'd5 && !to_pc |=> flag_c == ($past(rn_val) >= $past(sh_val)));

  assert_logic_carry_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid && logic_s && !to_pc |=> flag_c == $past(sh_carry) && flag_v == $past(flag_v));

  assert_compare_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid && cmp_code |=> !rd_we && !restore_req);

  assert_restore_holds_flags_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid && wr_code && op_code[0] && to_pc |=> restore_req && rd_we && $stable(fl));

  assert_unsupported_inert_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid && !wr_code && !cmp_code |=> !rd_we && !restore_req && $stable(fl));

  assert_issue_to_valid_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !rd_we && !restore_req && $stable(fl));

endmodule

bind dp_alu_unit dpalu_checker #(
  .DATA_W    (DATA_W),
  .REG_IDX_W (REG_IDX_W),
  .PC_REG    (PC_REG)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .op_code     (op_code),
  .rn_val      (rn_val),
  .sh_val      (sh_val),
  .sh_carry    (sh_carry),
  .rd_idx      (rd_idx),
  .out_valid   (out_valid),
  .result      (result),
  .rd_we       (rd_we),
  .restore_req (restore_req),
  .flag_n      (flag_n),
  .flag_z      (flag_z),
  .flag_c      (flag_c),
  .flag_v      (flag_v)
);

// File: tb/dp_alu_unit_tb_top.sv
`timescale 1ns/1ps
module dp_alu_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic [31:0] rn_val = '0;
  logic [31:0] sh_val = '0;
  logic        sh_carry = 1'b0;
  logic [3:0]  rd_idx = '0;
  logic        out_valid, rd_we, restore_req;
  logic [31:0] result;
  logic        flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int fails  = 0;
  logic [3:0] mflags = 4'b0000;   // model {n,z,c,v}
  logic [31:0] pa [10];
  logic [31:0] pb [10];

  always #10 clk = ~clk;          // 50 MHz

  dp_alu_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
    .rn_val(rn_val), .sh_val(sh_val), .sh_carry(sh_carry), .rd_idx(rd_idx),
    .out_valid(out_valid), .result(result), .rd_we(rd_we),
    .restore_req(restore_req), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] dut_flags();
    return {flag_n, flag_z, flag_c, flag_v};
  endfunction

  task automatic run_vec(input logic [4:0] code, input logic [31:0] a,
                         input logic [31:0] b, input logic cin, input logic [3:0] rd);
    logic [3:0]  opc = code[4:1];
    logic        s = code[0];
    logic        wr = (code <= 5'd9) || (code >= 5'd24);
    logic        cmp = (code == 5'd21) || (code == 5'd23);
    logic        lg = (opc <= 4'd1) || (opc >= 4'd12);
    logic        is_sub = (opc == 4'd2) || (opc == 4'd3) || (opc == 4'd10);
    logic [31:0] m1 = (opc == 4'd3) ? b : a;
    logic [31:0] m2 = (opc == 4'd3) ? a : b;
    logic [31:0] r = '0;
    logic        c = 1'b0, v = 1'b0;
    logic        ex_rs;
    logic [3:0]  prev = mflags;
    string       rtag, ftag;
    case (opc)
      4'd0:  r = a & b;
      4'd1:  r = a ^ b;
      4'd12: r = a | b;
      4'd13: r = b;
      4'd14: r = a & ~b;
      4'd15: r = ~b;
      default: begin
        if (is_sub) begin
          r = m1 - m2;
          c = (m1 >= m2);
          v = (((m1 ^ m2) & (r ^ m1)) >> 31) != 0;
        end else begin
          r = a + b;
          c = ({1'b0, a} + {1'b0, b}) > 33'h0_FFFF_FFFF;
          v = ((~(a ^ b) & (r ^ a)) >> 31) != 0;
        end
      end
    endcase
    ex_rs = s && wr && (rd == 4'd15);
    if (s && (wr || cmp) && !ex_rs)
      mflags = {r[31], r == 0, lg ? cin : c, lg ? prev[0] : v};
    rtag = lg ? "R2" : (cmp ? "R8" : "R3");
    if (!s)              ftag = "R1";
    else if (ex_rs)      ftag = "R9";
    else if (!(wr||cmp)) ftag = "R10";
    else if (lg)         ftag = "R7";
    else if (is_sub)     ftag = "R6";
    else                 ftag = "R5";

    @(negedge clk);
    in_valid = 1'b1; op_code = code; rn_val = a; sh_val = b;
    sh_carry = cin; rd_idx = rd;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R11", "out_valid after issue", 32'(out_valid), 32'd1);
    check(rd_we == wr, (wr || cmp) ? rtag : "R10", "rd_we", 32'(rd_we), 32'(wr));
    check(restore_req == ex_rs, ex_rs ? "R9" : (cmp ? "R8" : "R10"), "restore_req",
          32'(restore_req), 32'(ex_rs));
    if (wr || cmp)
      check(result == r, rtag, $sformatf("result code %0d", code), result, r);
    if (s && (wr || cmp) && !ex_rs)
      check(dut_flags() & 4'b1100 == mflags & 4'b1100 ? 1'b1 :
            (dut_flags() >> 2) == (mflags >> 2), "R4", "N,Z", 32'(dut_flags()), 32'(mflags));
    check(dut_flags() == mflags, ftag, $sformatf("flags code %0d", code),
          32'(dut_flags()), 32'(mflags));
    @(negedge clk);
    check(!out_valid && !rd_we && !restore_req, "R11", "idle outputs",
          {29'd0, out_valid, rd_we, restore_req}, 32'd0);
    check(dut_flags() == mflags, "R11", "flags hold while idle",
          32'(dut_flags()), 32'(mflags));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_2357;
    pa[0] = 32'h0000_0000; pb[0] = 32'h0000_0000;
    pa[1] = 32'h0000_0001; pb[1] = 32'h0000_0001;
    pa[2] = 32'h7FFF_FFFF; pb[2] = 32'h0000_0001;
    pa[3] = 32'h8000_0000; pb[3] = 32'h0000_0001;
    pa[4] = 32'hFFFF_FFFF; pb[4] = 32'h0000_0001;
    pa[5] = 32'h0000_0005; pb[5] = 32'h0000_0007;
    pa[6] = 32'h8000_0000; pb[6] = 32'h8000_0000;
    pa[7] = 32'h1234_5678; pb[7] = 32'h0F0F_0F0F;
    pa[8] = 32'h8000_0000; pb[8] = 32'h7FFF_FFFF;
    pa[9] = 32'hFFFF_FFFF; pb[9] = 32'hFFFF_FFFF;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: state after reset
    check(!out_valid && !rd_we && !restore_req, "R12", "control after reset",
          {29'd0, out_valid, rd_we, restore_req}, 32'd0);
    check(dut_flags() == 4'b0000, "R12", "flags after reset", 32'(dut_flags()), 32'd0);
    check(result == 32'd0, "R12", "result after reset", result, 32'd0);

    for (int code = 0; code < 32; code++)
      for (int p = 0; p < 10; p++)
        for (int k = 0; k < 4; k++)
          run_vec(5'(code), pa[p], pb[p], k[0], k[1] ? 4'd15 : 4'd3);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] x, y;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      x = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      y = lfsr;
      run_vec(5'(lfsr[8:4]), x, y, lfsr[2], lfsr[3] ? 4'd15 : lfsr[12:9]);
    end

    // R12: reset in the middle of operation clears set flags
    run_vec(5'd31, 32'd0, 32'd0, 1'b1, 4'd2);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mflags = 4'b0000;
    check(dut_flags() == 4'b0000, "R12", "flags cleared by reset",
          32'(dut_flags()), 32'd0);
    check(result == 32'd0, "R12", "result cleared by reset", result, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule